// File: doc/BRIEF.md
# Programmable Output Clock Divider

This block produces an auxiliary clock for a general-purpose pin from the system clock. A 4-bit select input picks one ratio from a fixed, irregular set: pass-through, /2, /3, /4, /5.5, /6, /8, /12 and /16. Codes 9 to 15 are reserved. A reserved code parks the output low and raises a flag. An enable input turns the output on and off.

All divided waveforms come from one register clocked on the rising edge of the system clock. The pass-through case uses a clock gate whose control changes only while the system clock is low. The block latches the select and enable values only at the end of the output period in progress. A setting change therefore never shortens or stretches a high or low phase already under way. The /5.5 ratio uses output periods of 5 and 6 input cycles in turn, so two periods always span 11 input cycles.

Top module: `aux_clk_div`

## Requirements
- R1: While rst_ni is low, and after its release with en_i = 0 and div_sel_i = 0, clk_o and rsvd_o are both 0.
- R2: When en_i is 0, clk_o goes low at the end of the current output period and stays low. A phase already in progress is not cut short.
- R3: With en_i = 1 and div_sel_i = 0, clk_o follows clk_i: it is high during the high half of clk_i and low during the low half.
- R4: Codes 1, 2 and 3 give rising-edge spacings of 2, 3 and 4 input cycles. The high phases last 1, 2 and 2 cycles, so the odd ratio /3 is high one cycle longer than it is low.
- R5: Code 4 gives rising-edge spacings that alternate between 5 and 6 input cycles. Each high phase lasts 3 cycles, and any two consecutive spacings sum to 11.
- R6: Codes 5, 6, 7 and 8 give rising-edge spacings of 6, 8, 12 and 16 input cycles, each with exactly half the period high.
- R7: With any code from 9 to 15 selected, rsvd_o is 1 and clk_o stays low, with no pulse.
- R8: The block applies a new div_sel_i or en_i value only at the end of the output period in progress. That period ends with its original high phase and length, and the next period uses the new setting and starts with its high phase.
- R9: In every divided mode, clk_o changes only at rising edges of clk_i and holds its level across the whole clk_i cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Output enable |
| div_sel_i | input | 4 | Ratio select code |
| clk_o | output | 1 | Auxiliary clock output |
| rsvd_o | output | 1 | A reserved code is in effect |

## Verification
A wrong phase counter or a wrong ratio decode shows at clk_o as a wrong rising-edge spacing or a wrong high-phase length within one output period, which is at most 16 input cycles after the new setting takes effect. A stuck or missing alternation flag for /5.5 shows as two equal spacings in a row, or as a pair that does not sum to 11. A configuration register that loads mid-period shows as a shortened period right after the select change. A gate that switches while clk_i is high shows as a clipped or absent high half in pass-through.

// File: rtl/aux_clk_pkg.sv
package aux_clk_pkg;
  localparam int CODE_W  = 4;
  localparam int MAX_DIV = 16;
  localparam int CNT_W   = $clog2(MAX_DIV);
  localparam int HI_W    = CNT_W + 1;

  localparam logic [CODE_W-1:0] CODE_BYP  = CODE_W'(0);
  localparam logic [CODE_W-1:0] CODE_FRAC = CODE_W'(4);
  localparam logic [CODE_W-1:0] CODE_LAST = CODE_W'(8);

  // hi: cycles high at period start; last: index of final cycle in period
  typedef struct packed {
    logic [HI_W-1:0]  hi;
    logic [CNT_W-1:0] last;
  } phase_t;

  function automatic phase_t mk_phase(int hi_cyc, int len_cyc);
    phase_t p;
    p.hi   = HI_W'(hi_cyc);
    p.last = CNT_W'(len_cyc - 1);
    return p;
  endfunction

  // disabled, reserved and pass-through all behave as 1-cycle idle periods
  function automatic phase_t decode(logic en, logic [CODE_W-1:0] code, logic alt);
    phase_t p;
    p = mk_phase(0, 1);
    if (en) begin
      case (code)
        CODE_W'(1): p = mk_phase(1, 2);
        CODE_W'(2): p = mk_phase(2, 3);
        CODE_W'(3): p = mk_phase(2, 4);
        CODE_W'(4): p = alt ? mk_phase(3, 6) : mk_phase(3, 5);
        CODE_W'(5): p = mk_phase(3, 6);
        CODE_W'(6): p = mk_phase(4, 8);
        CODE_W'(7): p = mk_phase(6, 12);
        CODE_W'(8): p = mk_phase(8, 16);
        default:    p = mk_phase(0, 1);
      endcase
    end
    return p;
  endfunction
endpackage

// File: rtl/aux_clk_seq.sv
module aux_clk_seq
  import aux_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] div_sel_i,
  output logic              div_o,
  output logic              bypass_o,
  output logic              rsvd_o
);
  logic              act_en;
  logic [CODE_W-1:0] act_code;
  logic              alt_q, alt_n;
  logic [CNT_W-1:0]  cnt_q;
  logic              div_q;
  phase_t            cur, nxt;
  logic              at_end, cur_frac, nxt_frac;
  logic [HI_W-1:0]   cnt_inc;

  assign cur      = decode(act_en, act_code, alt_q);
  assign at_end   = (cnt_q == cur.last);
  assign cur_frac = act_en && (act_code == CODE_FRAC);
  assign nxt_frac = en_i && (div_sel_i == CODE_FRAC);
  // /5.5 alternates 5- and 6-cycle periods while the mode persists
  assign alt_n    = (cur_frac && nxt_frac) ? ~alt_q : 1'b0;
  assign nxt      = decode(en_i, div_sel_i, alt_n);
  assign cnt_inc  = {1'b0, cnt_q} + HI_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en   <= 1'b0;
      act_code <= '0;
      alt_q    <= 1'b0;
      cnt_q    <= '0;
      div_q    <= 1'b0;
    end else if (at_end) begin
      act_en   <= en_i;
      act_code <= div_sel_i;
      alt_q    <= alt_n;
      cnt_q    <= '0;
      div_q    <= (nxt.hi != '0);
    end else begin
      cnt_q    <= cnt_q + CNT_W'(1);
      div_q    <= (cnt_inc < cur.hi);
    end
  end

  assign div_o    = div_q;
  assign bypass_o = act_en && (act_code == CODE_BYP);
  assign rsvd_o   = (act_code > CODE_LAST);

  assert_off_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_en |-> !div_q);
  assert_rsvd_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_o |-> !div_q);
  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> ($stable(act_code) && $stable(act_en)));
  assert_rise_at_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_q) |-> (cnt_q == '0));
endmodule

// File: rtl/aux_clk_gate.sv
module aux_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic div_i,
  output logic clk_o
);
  logic gate_q;

  // control sampled while clk_i is low so the gated clock cannot be clipped
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= bypass_i;
  end

  assign clk_o = (clk_i & gate_q) | div_i;
endmodule

// File: rtl/aux_clk_div.sv
module aux_clk_div
  import aux_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] div_sel_i,
  output logic              clk_o,
  output logic              rsvd_o
);
  logic div_w;
  logic bypass_w;

  aux_clk_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .div_sel_i (div_sel_i),
    .div_o     (div_w),
    .bypass_o  (bypass_w),
    .rsvd_o    (rsvd_o)
  );

  aux_clk_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (bypass_w),
    .div_i    (div_w),
    .clk_o    (clk_o)
  );

  assert_bypass_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_w |-> !div_w);
endmodule

// File: tb/aux_clk_div_bench.sv
module aux_clk_div_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 8;
  localparam logic [3:0] V_CODE [NV] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8};
  localparam int         V_P0   [NV] = '{2, 3, 4, 5, 6, 8, 12, 16};
  localparam int         V_P1   [NV] = '{2, 3, 4, 6, 6, 8, 12, 16};
  localparam int         V_HI   [NV] = '{1, 2, 2, 3, 3, 4, 6, 8};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] sel = 4'd0;
  logic       clk_out, rsvd;

  int  checks = 0;
  int  errs = 0;
  bit  done = 0;
  bit  s = 0, ps = 0;
  int  iv [4];
  int  hc [4];

  aux_clk_div u_aux_clk_div (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .div_sel_i (sel),
    .clk_o     (clk_out),
    .rsvd_o    (rsvd)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    ps = s;
    s  = clk_out;
  endtask

  task automatic wait_rise(output bit found);
    int g = 0;
    found = 0;
    while (g < 64 && !found) begin
      tick();
      g++;
      if (s && !ps) found = 1;
    end
  endtask

  // after a rise: cycles until the next rise, and high cycles within
  task automatic period(output int n, output int h);
    n = 1; h = 1;
    tick();
    while (!(s && !ps) && n < 64) begin
      n++;
      h += int'(s);
      tick();
    end
  endtask

  task automatic measure(input string req);
    bit f;
    wait_rise(f);
    chk(f, req, 0, 1);
    for (int k = 0; k < 4; k++) period(iv[k], hc[k]);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    int n, h, hs;
    bit f;
    string rq;

    // R1 reset state
    #2;
    chk(clk_out == 1'b0, "R1", int'(clk_out), 0);
    chk(rsvd == 1'b0, "R1", int'(rsvd), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    hs = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      hs += int'(s) + int'(rsvd);
    end
    chk(hs == 0, "R1", hs, 0);

    // table walk: R4 (codes 1-3), R5 (code 4), R6 (codes 5-8)
    en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      rq = (v < 3) ? "R4" : (v == 3) ? "R5" : "R6";
      sel = V_CODE[v];
      repeat (40) tick();
      measure(rq);
      for (int k = 0; k < 4; k++) begin
        if (V_P0[v] == V_P1[v])
          chk(iv[k] == V_P0[v], rq, iv[k], V_P0[v]);
        else begin
          chk(iv[k] == V_P0[v] || iv[k] == V_P1[v], rq, iv[k], V_P0[v]);
          if (k > 0)
            chk(iv[k] + iv[k-1] == V_P0[v] + V_P1[v], rq, iv[k] + iv[k-1], V_P0[v] + V_P1[v]);
        end
        chk(hc[k] == V_HI[v], rq, hc[k], V_HI[v]);
      end
      chk(rsvd == 1'b0, rq, int'(rsvd), 0);
    end

    // R9: divided output holds level across a whole clk_i cycle
    sel = 4'd3;
    repeat (20) tick();
    hs = 0;
    for (int i = 0; i < 16; i++) begin
      tick();
      #4;
      if (clk_out != s) hs++;
    end
    chk(hs == 0, "R9", hs, 0);

    // R3 pass-through
    sel = 4'd0;
    repeat (10) tick();
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(s == 1'b1, "R3", int'(s), 1);
      #5;
      chk(clk_out == 1'b0, "R3", int'(clk_out), 0);
    end
    // leaving pass-through: first divided periods are exact
    sel = 4'd3;
    repeat (6) tick();
    measure("R3");
    chk(iv[1] == 4 && hc[1] == 2, "R3", iv[1], 4);

    // R8: change code in mid-period, current /16 period completes
    sel = 4'd8;
    repeat (40) tick();
    wait_rise(f);
    n = 1; h = 1;
    for (int i = 0; i < 2; i++) begin
      tick();
      n++;
      h += int'(s);
    end
    sel = 4'd1;
    tick();
    while (!(s && !ps) && n < 64) begin
      n++;
      h += int'(s);
      tick();
    end
    chk(n == 16, "R8", n, 16);
    chk(h == 8, "R8", h, 8);
    period(n, h);
    chk(n == 2, "R8", n, 2);

    // R2 / R8: disable in mid-period, high phase still completes
    sel = 4'd6;
    repeat (40) tick();
    wait_rise(f);
    en = 1'b0;
    h = 1;
    n = 0;
    for (int i = 0; i < 30; i++) begin
      tick();
      h += int'(s);
      if (s && !ps) n++;
    end
    chk(h == 4, "R2", h, 4);
    chk(n == 0, "R2", n, 0);
    chk(rsvd == 1'b0, "R2", int'(rsvd), 0);

    // R7 reserved codes
    en = 1'b1;
    foreach (V_CODE[i]) begin end
    for (int c = 9; c <= 15; c += 6) begin
      sel = 4'(c);
      repeat (20) tick();
      hs = 0;
      for (int i = 0; i < 20; i++) begin
        tick();
        hs += int'(s);
        #5;
        hs += int'(clk_out);
        chk(rsvd == 1'b1, "R7", int'(rsvd), 1);
      end
      chk(hs == 0, "R7", hs, 0);
    end
    // recovery from reserved into /2
    sel = 4'd1;
    repeat (6) tick();
    measure("R7");
    chk(iv[2] == 2 && rsvd == 1'b0, "R7", iv[2], 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule